// File: doc/BRIEF.md
# Serial Gain Programmer for a Dual Amplifier

This block programs a two-channel programmable-gain amplifier over a shared SPI bus. A host presents one 4-bit gain code per channel and pulses a start strobe. The block checks both codes, packs them into one 8-bit command and shifts it out with the most significant bit first. Meanwhile it reads back the settings the amplifier had before, which the amplifier shifts out on its own data line during the same frame. The serial clock comes from the system clock through a divider whose half period is set per frame.

While a frame is in progress the block drives the select and enable lines of the other devices on the shared bus to their inactive level of 1, so that no other device answers. It holds the amplifier's shutdown input low at all times. A busy flag covers the whole frame. One cycle after the frame ends, a done pulse marks the cycle in which the returned echo value is valid.

Top module: `pga_gain_loader`

## Requirements
- R1: After reset: `amp_cs_n_o`=1, `sck_o`=0, `busy_o`=0, `done_o`=0, `echo_o`=0, and all four bus-disable outputs are 0.
- R2: The command word is {channel B code, channel A code}, so channel B sits in bits 7:4. Bit 7 is sent first. Each bit is on `mosi_o` before the rising edge of `sck_o` and changes only after a falling edge. The clock idles low.
- R3: A gain code from 8 to 15 is replaced by 0 before it is sent. Codes 0 to 7 are sent unchanged, with 0 meaning zero gain and 1 to 7 meaning gains of -1, -2, -5, -10, -20, -50 and -100.
- R4: `amp_cs_n_o` stays low for the whole frame, and exactly 8 rising edges of `sck_o` occur while it is low.
- R5: Each half period of `sck_o` lasts `clk_div_i`+1 system clocks, using the value captured at start. From the start strobe to the release of `amp_cs_n_o`, `busy_o` is high for exactly 17*(`clk_div_i`+1) cycles.
- R6: `done_o` is a one-cycle pulse. It is raised in the first cycle after `busy_o` falls.
- R7: While `done_o` is high, `echo_o` holds the 8 bits that `miso_i` presented at the 8 rising clock edges, with the first bit in bit 7.
- R8: A start strobe is ignored while `busy_o` is high. It starts no further frame and does not change the frame in progress.
- R9: `amp_shdn_o` is 0 at all times.
- R10: `flash_sel_o`, `dac_sel_o`, `pflash_ce_o` and `pflash_init_o` are 1 while `busy_o` is high and 0 while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, accepted only while idle |
| gain_a_i | input | 4 | Gain code for channel A |
| gain_b_i | input | 4 | Gain code for channel B |
| clk_div_i | input | DIV_W | Serial clock half period minus one, in system clocks |
| miso_i | input | 1 | Echo data from the amplifier |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| echo_o | output | 8 | Previous amplifier settings read back during the frame |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial command data |
| amp_cs_n_o | output | 1 | Active-low amplifier select |
| amp_shdn_o | output | 1 | Amplifier shutdown, always held low |
| flash_sel_o | output | 1 | Serial flash select, inactive level while busy |
| dac_sel_o | output | 1 | DAC select, inactive level while busy |
| pflash_ce_o | output | 1 | Parallel flash enable, inactive level while busy |
| pflash_init_o | output | 1 | Platform flash init line, inactive level while busy |

## Verification
The embedded properties check on every cycle the relations between the framing signals:
- the select is low only while busy and the clock is low while the select is released;
- data is held still during every high clock phase;
- the done pulse lasts one cycle and directly follows the busy period;
- the first bit of every frame is 0, because reserved codes are replaced;
- the other devices' lines are at their inactive level whenever the select is low;
- the divider count never passes the captured half period.

Only the bench scenarios show what the bits mean: the word the amplifier model receives, the echo returned from the preceding frame, the exact busy length for several divider values, and that a strobe issued in mid-frame starts nothing.

// File: rtl/pga_pkg.sv
package pga_pkg;
  localparam int GAIN_W     = 4;
  localparam int CMD_W      = 2 * GAIN_W;
  localparam int GAIN_LEGAL = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_TAIL = 2'd2
  } pga_state_t;

  // Codes above the legal range are reserved and map to zero gain.
  function automatic logic [GAIN_W-1:0] gain_clean(input logic [GAIN_W-1:0] code);
    gain_clean = (int'(code) > GAIN_LEGAL) ? '0 : code;
  endfunction
endpackage

// File: rtl/pga_rst_sync.sv
module pga_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pga_tick_gen.sv
module pga_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == div_q);

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    if (load_i) begin
      div_d = div_i;
      cnt_d = '0;
    end else if (!run_i || tick_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_q);
endmodule

// File: rtl/pga_shift_eng.sv
module pga_shift_eng
  import pga_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] word_i,
  input  logic         tick_i,
  input  logic         miso_i,
  output logic         load_o,
  output logic         busy_o,
  output logic         done_o,
  output logic         sck_o,
  output logic         mosi_o,
  output logic         cs_n_o,
  output logic [W-1:0] echo_o
);
  localparam int BIT_W = $clog2(W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W - 1);

  pga_state_t state_q, state_d;
  logic [W-1:0]     tx_q, tx_d;
  logic [W-1:0]     rx_q, rx_d;
  logic [W-1:0]     echo_q, echo_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic sck_q, sck_d, cs_n_q, cs_n_d, mosi_q, mosi_d, done_q, done_d;

  assign load_o = start_i && (state_q == ST_IDLE);
  assign busy_o = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    echo_d  = echo_q;
    bit_d   = bit_q;
    sck_d   = sck_q;
    cs_n_d  = cs_n_q;
    mosi_d  = mosi_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          tx_d    = word_i;
          mosi_d  = word_i[W-1];
          cs_n_d  = 1'b0;
          sck_d   = 1'b0;
          bit_d   = '0;
          state_d = ST_XFER;
        end
      end
      ST_XFER: begin
        if (tick_i) begin
          sck_d = ~sck_q;
          if (!sck_q) begin
            rx_d = {rx_q[W-2:0], miso_i};
          end else if (bit_q == LAST_BIT) begin
            state_d = ST_TAIL;
          end else begin
            bit_d  = bit_q + 1'b1;
            tx_d   = {tx_q[W-2:0], 1'b0};
            mosi_d = tx_q[W-2];
          end
        end
      end
      ST_TAIL: begin
        if (tick_i) begin
          cs_n_d  = 1'b1;
          done_d  = 1'b1;
          echo_d  = rx_q;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tx_q    <= '0;
      rx_q    <= '0;
      echo_q  <= '0;
      bit_q   <= '0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      mosi_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      echo_q  <= echo_d;
      bit_q   <= bit_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
      mosi_q  <= mosi_d;
      done_q  <= done_d;
    end
  end

  assign sck_o  = sck_q;
  assign cs_n_o = cs_n_q;
  assign mosi_o = mosi_q;
  assign done_o = done_q;
  assign echo_o = echo_q;

  // R4
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_q |-> busy_o);
  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sck_q);
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(mosi_q));
  // R6
  done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/pga_gain_loader.sv
module pga_gain_loader
  import pga_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [3:0]       gain_a_i,
  input  logic [3:0]       gain_b_i,
  input  logic [DIV_W-1:0] clk_div_i,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       echo_o,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             amp_cs_n_o,
  output logic             amp_shdn_o,
  output logic             flash_sel_o,
  output logic             dac_sel_o,
  output logic             pflash_ce_o,
  output logic             pflash_init_o
);
  logic rst_n_s;
  logic load, tick, busy;
  logic [CMD_W-1:0] word;

  pga_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  // Channel B occupies the upper nibble and therefore goes out first.
  assign word = {gain_clean(gain_b_i), gain_clean(gain_a_i)};

  pga_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (load),
    .div_i  (clk_div_i),
    .run_i  (busy),
    .tick_o (tick)
  );

  pga_shift_eng #(.W(CMD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start_i (start_i),
    .word_i  (word),
    .tick_i  (tick),
    .miso_i  (miso_i),
    .load_o  (load),
    .busy_o  (busy),
    .done_o  (done_o),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .cs_n_o  (amp_cs_n_o),
    .echo_o  (echo_o)
  );

  assign busy_o        = busy;
  assign amp_shdn_o    = 1'b0;
  assign flash_sel_o   = busy;
  assign dac_sel_o     = busy;
  assign pflash_ce_o   = busy;
  assign pflash_init_o = busy;

  // R10
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !amp_cs_n_o |-> (flash_sel_o && dac_sel_o && pflash_ce_o && pflash_init_o));
  // R3
  first_bit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(amp_cs_n_o) |-> !mosi_o);
endmodule

// File: tb/test_pga_gain_loader.sv
module test_pga_gain_loader;
  localparam int DIV_W = 8;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] echo;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [3:0] ga, gb;
  logic [DIV_W-1:0] div;
  logic miso;
  logic busy, done, sck, mosi, cs_n, shdn, fsel, dsel, pce, pinit;
  logic [7:0] echo;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  exp_t sb[$];
  logic [7:0] last_cmd = 8'h00;

  // amplifier model
  logic [7:0] amp_prev = 8'h00;
  logic [7:0] amp_tx = 8'h00;
  logic [7:0] amp_rx = 8'h00;
  int rises = 0;
  int frames = 0;
  bit in_frame = 0;
  int mosi_viol = 0;
  int quiet_viol = 0;

  always #2.5 clk = ~clk;

  pga_gain_loader #(.DIV_W(DIV_W)) i_pga_gain_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .gain_a_i(ga), .gain_b_i(gb),
    .clk_div_i(div), .miso_i(miso), .busy_o(busy), .done_o(done), .echo_o(echo),
    .sck_o(sck), .mosi_o(mosi), .amp_cs_n_o(cs_n), .amp_shdn_o(shdn),
    .flash_sel_o(fsel), .dac_sel_o(dsel), .pflash_ce_o(pce), .pflash_init_o(pinit)
  );

  always @(negedge cs_n) begin
    in_frame = 1; frames++; rises = 0; amp_tx = amp_prev; miso = amp_tx[7];
  end
  always @(posedge sck) if (!cs_n) begin
    amp_rx = {amp_rx[6:0], mosi}; rises++;
  end
  always @(negedge sck) if (!cs_n) begin
    amp_tx = {amp_tx[6:0], 1'b0}; miso = amp_tx[7];
  end
  always @(posedge cs_n) if (in_frame) begin
    in_frame = 0; amp_prev = amp_rx;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] clean(input logic [3:0] c);
    return (c > 4'd7) ? 4'd0 : c;
  endfunction

  // continuous observation, sampled away from the active edge
  initial begin
    logic ps = 0, pm = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (sck && ps && (mosi != pm)) mosi_viol++;
        if (shdn !== 1'b0) quiet_viol++;
        if (busy && !(fsel && dsel && pce && pinit)) quiet_viol++;
        if (!busy && (fsel || dsel || pce || pinit)) quiet_viol++;
      end
      ps = sck; pm = mosi;
    end
  end

  // monitor: pops the scoreboard at each done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (done === 1'b1) begin
        exp_t e;
        if (sb.size() == 0) begin
          check(0, "R8", "unexpected frame", 1, 0);
        end else begin
          e = sb.pop_front();
          check(echo == e.echo, "R7", "echo", echo, e.echo);
          check(amp_rx == e.cmd, "R2 R3", "command word", amp_rx, e.cmd);
          check(rises == 8, "R4", "clock rises", rises, 8);
          check(busy == 1'b0, "R6", "busy at done", busy, 0);
        end
        @(negedge clk);
        check(done == 1'b0, "R6", "done width", done, 0);
      end
    end
  end

  task automatic send(input logic [3:0] a, input logic [3:0] b,
                      input int d, input bit poke);
    exp_t e;
    int cnt = 0;
    int f0;
    while (busy) @(negedge clk);
    e.cmd  = {clean(b), clean(a)};
    e.echo = last_cmd;
    last_cmd = e.cmd;
    sb.push_back(e);
    f0 = frames;
    ga = a; gb = b; div = DIV_W'(d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) begin
      cnt++;
      if (poke && cnt == 3) begin
        ga = 4'd2; gb = 4'd3; div = 8'd0; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    // R5 busy length
    check(cnt == 17 * (d + 1), "R5", "busy cycles", cnt, 17 * (d + 1));
    repeat (30) begin
      @(negedge clk);
      if (busy) cnt = -1;
    end
    // R8 no extra frame started
    check(cnt != -1 && frames == f0 + 1, "R8", "frames per start", frames - f0, 1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; ga = '0; gb = '0; div = '0; miso = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(cs_n == 1 && sck == 0 && busy == 0 && done == 0, "R1", "idle lines",
          {cs_n, sck, busy, done}, 4'b1000);
    check(echo == 8'h00, "R1", "echo reset", echo, 0);
    check({fsel, dsel, pce, pinit} == 4'b0000, "R10", "disables idle",
          {fsel, dsel, pce, pinit}, 0);
    check(shdn == 1'b0, "R9", "shutdown low", shdn, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    send(4'd1, 4'd7, 0, 0);
    send(4'd3, 4'd5, 2, 0);
    send(4'd9, 4'd15, 1, 0);   // R3 both reserved
    send(4'hC, 4'd2, 3, 0);    // R3 channel A reserved
    send(4'd7, 4'd8, 0, 0);    // R3 channel B reserved
    send(4'd6, 4'd4, 1, 1);    // R8 strobe mid-frame
    send(4'd4, 4'd6, 5, 0);
    send(4'd0, 4'd1, 0, 0);

    check(sb.size() == 0, "R7", "scoreboard drained", sb.size(), 0);
    check(mosi_viol == 0, "R2", "data change in high clock", mosi_viol, 0);
    check(quiet_viol == 0, "R9 R10", "bus lines", quiet_viol, 0);
    check({fsel, dsel, pce, pinit} == 4'b0000, "R10", "disables after",
          {fsel, dsel, pce, pinit}, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule